// File: doc/BRIEF.md
# Chip-enable framed serial register port

This block is the slave end of a three-wire serial control bus, with an open-drain return line. The host holds the chip-enable line low and clocks in an 8-bit device code, least significant bit first. When chip enable rises, the block commits to one of four transfer modes, based on that code. The block then samples the data line on each rising serial clock edge and updates its output after each falling edge.

The four modes work as follows:
- **Write mode** collects a 16-bit word. The word holds a data byte, a 4-bit register index and four padding bits. The block commits the word to a small register file when chip enable falls.
- **Packet-read mode** sends out a 288-bit buffer that was loaded earlier from a parallel port.
- **Register-read mode** sends out the register that the most recent write selected.
- **Byte-stream mode** passes each completed 8-bit group to a downstream checker, as a one-cycle strobe with a data byte.

All three serial pins are synchronised into the system clock and edge-detected. The serial clock must therefore be several times slower than the system clock.

Top module: `cef_serial_port`

## Requirements
- R1: The device code is the 8 bits clocked in while chip enable is low. The first bit received is code bit 0. The mode is fixed on the rising edge of chip enable: 0xFA selects write, 0xFB packet read, 0xFC byte stream and 0xFD register read.
- R2: In write mode the 16 bits received form a word whose bit i is the i-th bit received. Bits 7..0 are the data byte and bits 11..8 the register index. Bits 15..12 are padding with no effect. The byte is stored in the indexed register when chip enable falls after exactly 16 bits.
- R3: A write frame with a bit count other than 16 leaves every register unchanged.
- R4: In packet-read mode, bit 0 of the buffer is presented once chip enable is high. The next bit is presented after each falling serial clock edge, through bit 287. After that the line is released. The buffer is captured from `pkt_data_i` on a cycle where `pkt_load_i` is high.
- R5: In register-read mode, the 8 bits of the register last written are presented LSB first, one per falling clock edge, and the line is then released.
- R6: In byte-stream mode, every eighth received bit produces a one-cycle `byte_valid_o` pulse. The byte carries the first bit of its group in bit 0. A partial group at the end of the frame produces no pulse.
- R7: An unknown code, or an address phase that is not exactly 8 bits long, leaves the block idle until the next address phase. While idle the block performs no write, raises no strobe and never pulls the output low.
- R8: `do_pull_low_o` is high only while a read mode is presenting a 0 bit. Otherwise the line is left released, including whenever chip enable is low.
- R9: After reset, all registers read 0, the last-written index is 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable from the host |
| cl_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| pkt_load_i | input | 1 | Capture strobe for the packet buffer |
| pkt_data_i | input | PKT_BITS | Packet contents to capture |
| do_pull_low_o | output | 1 | Open-drain enable: 1 drives the line low |
| byte_valid_o | output | 1 | One-cycle strobe per completed stream byte |
| byte_data_o | output | 8 | Byte delivered with the strobe |

## Verification
The bench builds the block with its default parameters: a 288-bit packet, a 4-bit register index and two synchroniser stages.

With these values, a read can run the full packet length and go past its end, so the line release after bit 287 is observed. Random writes can reach both index extremes, 0 and 15.

The synchroniser depth sets the serial half period the bench uses. Misordered or miscounted address and data phases can then be placed exactly on frame boundaries.

// File: rtl/cef_pkg.sv
package cef_pkg;

  localparam int ADDR_W   = 8;
  localparam int FRAME_W  = 16;
  localparam int BYTE_W   = 8;
  localparam int RIDX_W   = 4;

  localparam logic [ADDR_W-1:0] CODE_WRITE = 8'hFA;
  localparam logic [ADDR_W-1:0] CODE_PKT   = 8'hFB;
  localparam logic [ADDR_W-1:0] CODE_BYTE  = 8'hFC;
  localparam logic [ADDR_W-1:0] CODE_REG   = 8'hFD;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_WRITE = 3'd1,
    MD_PKT   = 3'd2,
    MD_BYTE  = 3'd3,
    MD_REG   = 3'd4
  } mode_e;

  function automatic mode_e decode_code(input logic [ADDR_W-1:0] code);
    case (code)
      CODE_WRITE: return MD_WRITE;
      CODE_PKT:   return MD_PKT;
      CODE_BYTE:  return MD_BYTE;
      CODE_REG:   return MD_REG;
      default:    return MD_IDLE;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] word_data(input logic [FRAME_W-1:0] w);
    return w[BYTE_W-1:0];
  endfunction

  function automatic logic [RIDX_W-1:0] word_index(input logic [FRAME_W-1:0] w);
    return w[BYTE_W +: RIDX_W];
  endfunction

  function automatic logic is_read_mode(input mode_e m);
    return (m == MD_PKT) || (m == MD_REG);
  endfunction

endpackage

// File: rtl/cef_edge_sync.sv
module cef_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/cef_frame_ctrl.sv
module cef_frame_ctrl
  import cef_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lvl,
  input  logic              ce_rise,
  input  logic              ce_fall,
  input  logic              cl_rise,
  input  logic              di,
  output mode_e             mode_o,
  output logic              addr_known_o,
  output logic              wr_commit_o,
  output logic [RIDX_W-1:0] wr_index_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_data_o
);

  localparam int ACW = $clog2(ADDR_W + 2);
  localparam int DCW = $clog2(FRAME_W + 2);
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [ACW-1:0] ADDR_FULL = ACW'(ADDR_W);
  localparam logic [ACW-1:0] ADDR_SAT  = ACW'(ADDR_W + 1);
  localparam logic [DCW-1:0] DATA_FULL = DCW'(FRAME_W);
  localparam logic [DCW-1:0] DATA_SAT  = DCW'(FRAME_W + 1);
  localparam logic [BCW-1:0] BYTE_LAST = BCW'(BYTE_W - 1);

  mode_e               mode_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [ACW-1:0]      addr_cnt_q;
  logic [FRAME_W-1:0]  word_q;
  logic [DCW-1:0]      data_cnt_q;
  logic [BYTE_W-1:0]   grp_q;
  logic [BCW-1:0]      grp_idx_q;
  logic                bv_q;
  logic [BYTE_W-1:0]   bd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_IDLE;
      addr_q     <= '0;
      addr_cnt_q <= '0;
      word_q     <= '0;
      data_cnt_q <= '0;
      grp_q      <= '0;
      grp_idx_q  <= '0;
      bv_q       <= 1'b0;
      bd_q       <= '0;
    end else begin
      bv_q <= 1'b0;
      if (ce_rise) begin
        mode_q     <= (addr_cnt_q == ADDR_FULL) ? decode_code(addr_q) : MD_IDLE;
        data_cnt_q <= '0;
        grp_idx_q  <= '0;
      end else if (ce_fall) begin
        mode_q     <= MD_IDLE;
        addr_cnt_q <= '0;
      end else if (cl_rise) begin
        if (!ce_lvl) begin
          addr_q <= {di, addr_q[ADDR_W-1:1]};
          if (addr_cnt_q != ADDR_SAT) addr_cnt_q <= addr_cnt_q + 1'b1;
        end else if (mode_q == MD_WRITE) begin
          word_q <= {di, word_q[FRAME_W-1:1]};
          if (data_cnt_q != DATA_SAT) data_cnt_q <= data_cnt_q + 1'b1;
        end else if (mode_q == MD_BYTE) begin
          grp_q     <= {di, grp_q[BYTE_W-1:1]};
          grp_idx_q <= grp_idx_q + 1'b1;
          if (grp_idx_q == BYTE_LAST) begin
            bv_q <= 1'b1;
            bd_q <= {di, grp_q[BYTE_W-1:1]};
          end
        end
      end
    end
  end

  assign mode_o       = mode_q;
  assign addr_known_o = (addr_cnt_q == ADDR_FULL) && (decode_code(addr_q) != MD_IDLE);
  assign wr_commit_o  = ce_fall && (mode_q == MD_WRITE) && (data_cnt_q == DATA_FULL);
  assign wr_index_o   = word_index(word_q);
  assign wr_data_o    = word_data(word_q);
  assign byte_valid_o = bv_q;
  assign byte_data_o  = bd_q;

endmodule

// File: rtl/cef_reg_file.sv
module cef_reg_file #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [AW-1:0]        widx_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [(1<<AW)*DW-1:0] flat_o
);

  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];
  logic [AW-1:0] last_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs_q[r] <= '0;
      else if (we_i && (widx_i == AW'(r)))        regs_q[r] <= wdata_i;
    end
    assign flat_o[r*DW +: DW] = regs_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= '0;
    else if (we_i) last_q <= widx_i;
  end

  assign rdata_o = regs_q[last_q];

endmodule

// File: rtl/cef_tx_shift.sv
module cef_tx_shift
  import cef_pkg::*;
#(
  parameter int PKT_BITS = 288,
  parameter int IW       = $clog2(PKT_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mode_e               mode_i,
  input  logic                ce_rise,
  input  logic                cl_fall,
  input  logic                load_i,
  input  logic [PKT_BITS-1:0] pkt_i,
  input  logic [BYTE_W-1:0]   reg_byte_i,
  output logic [IW-1:0]       idx_o,
  output logic                pull_low_o
);

  localparam logic [IW-1:0] PKT_LIM = IW'(PKT_BITS);
  localparam logic [IW-1:0] REG_LIM = IW'(BYTE_W);

  logic [PKT_BITS-1:0] pkt_q;
  logic [IW-1:0]       idx_q;
  logic [IW-1:0]       lim;
  logic                active;
  logic                cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pkt_q <= '0;
    else if (load_i) pkt_q <= pkt_i;
  end

  assign lim    = (mode_i == MD_PKT) ? PKT_LIM : REG_LIM;
  assign active = is_read_mode(mode_i) && (idx_q < lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 idx_q <= '0;
    else if (ce_rise)           idx_q <= '0;
    else if (cl_fall && active) idx_q <= idx_q + 1'b1;
  end

  always_comb begin
    cur_bit = 1'b1;
    if (mode_i == MD_PKT && active)      cur_bit = pkt_q[idx_q];
    else if (mode_i == MD_REG && active) cur_bit = reg_byte_i[idx_q[$clog2(BYTE_W)-1:0]];
  end

  assign idx_o      = idx_q;
  assign pull_low_o = active & ~cur_bit;

endmodule

// File: rtl/cef_serial_port.sv
module cef_serial_port
  import cef_pkg::*;
#(
  parameter int PKT_BITS    = 288,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_i,
  input  logic                cl_i,
  input  logic                di_i,
  input  logic                pkt_load_i,
  input  logic [PKT_BITS-1:0] pkt_data_i,
  output logic                do_pull_low_o,
  output logic                byte_valid_o,
  output logic [7:0]          byte_data_o
);

  localparam int NPIN = 3;
  localparam int IW   = $clog2(PKT_BITS + 1);
  localparam int NREG = 1 << RIDX_W;

  logic [NPIN-1:0] pin_w, lvl_w, rise_w, fall_w;
  assign pin_w = {di_i, cl_i, ce_i};

  for (genvar k = 0; k < NPIN; k++) begin : g_sync
    cef_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_w[k]),
      .lvl_o(lvl_w[k]), .rise_o(rise_w[k]), .fall_o(fall_w[k])
    );
  end

  logic ce_lvl_w, ce_rise_w, ce_fall_w, cl_rise_w, cl_fall_w, di_w;
  assign ce_lvl_w  = lvl_w[0];
  assign ce_rise_w = rise_w[0];
  assign ce_fall_w = fall_w[0];
  assign cl_rise_w = rise_w[1];
  assign cl_fall_w = fall_w[1];
  assign di_w      = lvl_w[2];

  mode_e                  mode_w;
  logic                   addr_known_w;
  logic                   wr_commit_w;
  logic [RIDX_W-1:0]      wr_index_w;
  logic [BYTE_W-1:0]      wr_data_w;
  logic [BYTE_W-1:0]      rd_byte_w;
  logic [NREG*BYTE_W-1:0] regs_flat_w;
  logic [IW-1:0]          tx_idx_w;

  cef_frame_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .ce_lvl(ce_lvl_w), .ce_rise(ce_rise_w),
    .ce_fall(ce_fall_w), .cl_rise(cl_rise_w), .di(di_w),
    .mode_o(mode_w), .addr_known_o(addr_known_w), .wr_commit_o(wr_commit_w),
    .wr_index_o(wr_index_w), .wr_data_o(wr_data_w),
    .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o)
  );

  cef_reg_file #(.AW(RIDX_W), .DW(BYTE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we_i(wr_commit_w), .widx_i(wr_index_w),
    .wdata_i(wr_data_w), .rdata_o(rd_byte_w), .flat_o(regs_flat_w)
  );

  cef_tx_shift #(.PKT_BITS(PKT_BITS), .IW(IW)) tx_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .ce_rise(ce_rise_w),
    .cl_fall(cl_fall_w), .load_i(pkt_load_i), .pkt_i(pkt_data_i),
    .reg_byte_i(rd_byte_w), .idx_o(tx_idx_w), .pull_low_o(do_pull_low_o)
  );

endmodule

// File: rtl/cef_serial_port_chk.sv
module cef_serial_port_chk
  import cef_pkg::*;
#(
  parameter int PKT_BITS = 288,
  parameter int IW       = 9,
  parameter int FLAT_W   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input mode_e             mode,
  input logic              ce_rise,
  input logic              ce_fall,
  input logic              addr_known,
  input logic              wr_commit,
  input logic [FLAT_W-1:0] regs_flat,
  input logic [IW-1:0]     tx_idx,
  input logic              do_pull_low,
  input logic              byte_valid
);

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_rise && !ce_fall) |=> $stable(mode)); // R1

  AST_REGS_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(regs_flat)); // R3

  AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idx <= IW'(PKT_BITS)); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R6

  AST_STROBE_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(mode) == MD_BYTE); // R6

  AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && !addr_known) |=> mode == MD_IDLE); // R7

  AST_RELEASE_OUTSIDE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_PKT && mode != MD_REG) |-> !do_pull_low); // R8

endmodule

bind cef_serial_port cef_serial_port_chk #(
  .PKT_BITS(PKT_BITS), .IW(IW), .FLAT_W(NREG*BYTE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode_w), .ce_rise(ce_rise_w),
  .ce_fall(ce_fall_w), .addr_known(addr_known_w), .wr_commit(wr_commit_w),
  .regs_flat(regs_flat_w), .tx_idx(tx_idx_w), .do_pull_low(do_pull_low_o),
  .byte_valid(byte_valid_o)
);

// File: tb/cef_serial_port_tb.sv
module cef_serial_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HP         = 6;
  localparam int PKT_BITS   = 288;
  localparam int NREG       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, cl = 1'b0, di = 1'b0, pkt_load = 1'b0;
  logic [PKT_BITS-1:0] pkt_data = '0;
  logic       pull_low, bvalid;
  logic [7:0] bdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  cef_serial_port #(.PKT_BITS(PKT_BITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .pkt_load_i(pkt_load), .pkt_data_i(pkt_data),
    .do_pull_low_o(pull_low), .byte_valid_o(bvalid), .byte_data_o(bdata)
  );

  int total = 0, bad = 0, gcnt = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];
  int last_idx = 0;
  logic [PKT_BITS+15:0] rx;
  logic [7:0] got [64];

  always @(negedge clk) if (rst_n && bvalid) begin
    if (gcnt < 64) got[gcnt] = bdata;
    gcnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    di = b; wait_hp(); cl = 1'b1; wait_hp(); cl = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) clock_bit(v[i]);
  endtask

  task automatic raise_ce();
    wait_hp(); ce = 1'b1; wait_hp();
  endtask

  task automatic close_frame();
    wait_hp(); ce = 1'b0; wait_hp(); wait_hp();
  endtask

  // word layout per R2: padding in 15..12, index in 11..8, data in 7..0
  function automatic logic [15:0] make_word(input logic [3:0] idx, input logic [7:0] d);
    logic [3:0] pad;
    pad = 4'($urandom);
    return {pad, idx, d};
  endfunction

  task automatic write_frame(input logic [7:0] code, input logic [3:0] idx,
                             input logic [7:0] d, input int n, input bit expect_commit);
    send_bits({24'h0, code}, 8);
    raise_ce();
    send_bits({make_word(idx, d), make_word(idx, d)}, n);
    close_frame();
    if (expect_commit) begin
      model[idx] = d;
      last_idx = idx;
    end
  endtask

  task automatic read_frame(input logic [7:0] code, input int n);
    send_bits({24'h0, code}, 8);
    raise_ce();
    for (int i = 0; i < n; i++) begin
      rx[i] = ~pull_low;
      cl = 1'b1; wait_hp(); cl = 1'b0; wait_hp();
    end
    close_frame();
  endtask

  task automatic check_reg(input string req);
    read_frame(8'hFD, 10);
    chk(rx[7:0] == model[last_idx] && rx[9:8] == 2'b11, req,
        {22'h0, rx[9:0]}, {22'h0, 2'b11, model[last_idx]});
  endtask

  task automatic check_packet(input string req);
    int mism;
    mism = 0;
    pkt_load = 1'b1; @(negedge clk); pkt_load = 1'b0;
    read_frame(8'hFB, PKT_BITS + 4);
    for (int i = 0; i < PKT_BITS; i++) if (rx[i] != pkt_data[i]) mism++;
    for (int i = PKT_BITS; i < PKT_BITS + 4; i++) if (rx[i] != 1'b1) mism++;
    chk(mism == 0, req, mism, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk(pull_low == 1'b0 && bvalid == 1'b0, "R9 reset outputs", {bvalid, pull_low}, 0);
    check_reg("R9 R5 register read after reset");

    // R2 R5: index extremes, then random traffic
    write_frame(8'hFA, 4'd15, 8'hA5, 16, 1'b1);
    check_reg("R2 R5 write index 15");
    write_frame(8'hFA, 4'd0, 8'h01, 16, 1'b1);
    check_reg("R2 R5 write index 0");
    for (int k = 0; k < 10; k++) begin
      write_frame(8'hFA, 4'($urandom), 8'($urandom), 16, 1'b1);
      check_reg("R1 R2 R5 random write");
    end

    // R3: short and long frames are discarded
    write_frame(8'hFA, 4'(last_idx), ~model[last_idx], 15, 1'b0);
    check_reg("R3 15-bit frame discarded");
    write_frame(8'hFA, 4'(last_idx), ~model[last_idx], 17, 1'b0);
    check_reg("R3 17-bit frame discarded");

    // R7: bit-reversed and unknown codes stay idle
    write_frame(8'h5F, 4'(last_idx), ~model[last_idx], 16, 1'b0);
    check_reg("R1 R7 reversed code does not write");
    read_frame(8'hFE, 12);
    chk(rx[11:0] == 12'hFFF, "R7 R8 unknown code leaves line released", {20'h0, rx[11:0]}, 32'hFFF);
    begin
      logic [15:0] w;
      w = make_word(4'(last_idx), ~model[last_idx]);
      send_bits({24'h0, 8'hFA, 1'b1}, 9);
      raise_ce();
      send_bits({16'h0, w}, 16);
      close_frame();
    end
    check_reg("R7 nine-bit address phase ignored");

    // R4: random and alternating packets
    for (int i = 0; i < PKT_BITS; i++) pkt_data[i] = 1'($urandom);
    check_packet("R4 R8 random packet readout");
    for (int i = 0; i < PKT_BITS; i++) pkt_data[i] = i[0];
    check_packet("R4 alternating packet readout");

    // R6: five bytes then a partial group
    begin
      logic [7:0] sent [5];
      gcnt = 0;
      send_bits({24'h0, 8'hFC}, 8);
      raise_ce();
      for (int b = 0; b < 5; b++) begin
        sent[b] = 8'($urandom);
        send_bits({24'h0, sent[b]}, 8);
      end
      send_bits(32'h5, 3);
      close_frame();
      chk(gcnt == 5, "R6 strobe count", gcnt, 5);
      for (int b = 0; b < 5; b++)
        chk(got[b] == sent[b], "R6 stream byte", {24'h0, got[b]}, {24'h0, sent[b]});
    end

    chk(pull_low == 1'b0, "R8 released while chip enable low", {31'h0, pull_low}, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule